// File: doc/BRIEF.md
# Laser Safety Fault Latch Controller

This block decides whether a laser driver's bias and modulation currents may be on. Two inputs gate the currents: a software enable bit and a hardware disable pin. A latch also gates them. It catches three kinds of trouble. The first two come from analog comparators as asynchronous flags: the bias monitor voltage is over its limit, or the photodiode current is over 150% of its target. The third is computed here. Every write of the bias DAC code is compared with the code written before it. If the new code is less than half of the old one, the write counts as a fault.

While fault detection is armed, any fault source turns both currents off and sets the fault flag. The flag stays set after the source goes away. The latch clears only when the driver is held disabled for a minimum number of clock cycles, by the pin going high or the enable bit going low. A shorter disable does not clear it. When the disable ends, the currents come back only after a resume delay, with the previous settings intact. If the fault is still present at that point, the flag sets again and the currents stay off.

Top module: `lsf_fault_guard`

## Requirements
- R1: After reset the fault flag is low and both current enables are low. The enables rise only after RESUME_CYC consecutive clock cycles in which the driver is not disabled, not latched and sees no armed fault.
- R2: A comparator flag held high while armed and not disabled sets the fault flag. With SYNC_STAGES synchronizer stages, this happens on the clock edge SYNC_STAGES+1 edges after the flag is first sampled. Both enables are low in the same cycle, and the flag stays set after the source drops.
- R3: A disable, meaning tx_disable high or drv_enable low, drops both enables in the same cycle without a clock edge. After the disable ends, the enables return once the RESUME_CYC count is complete.
- R4: A bias code write is a step-drop fault when twice the new unsigned code is less than the previously written code. The previous code is zero after reset. A new code of exactly half the old one is not a fault. Only cycles with bias_code_wr high are compared.
- R5: With fault_arm low, no fault source sets the flag. This includes step drops written while unarmed, which are also not remembered.
- R6: A disable lasting fewer than RST_CYC consecutive cycles leaves a set fault flag set.
- R7: A disable held for RST_CYC consecutive cycles clears the flag at the edge that ends the RST_CYC-th cycle. The flag then stays low for as long as the disable lasts, even with a fault source active.
- R8: When a clearing disable ends, a still-present fault sets the flag again on the first edge after release, and the enables stay low. If no fault remains, the enables return after RESUME_CYC cycles.
- R9: A detected step drop stays pending until a clearing disable removes it. A drop written during a disable that has already cleared the latch sets the flag on the first edge after release.
- R10: bias_on and mod_on are always equal, and neither is high while the fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_enable | input | 1 | Software enable bit; low disables the driver |
| tx_disable | input | 1 | Hardware disable pin; high disables the driver |
| fault_arm | input | 1 | Fault detection enable |
| mon_hi_async | input | 1 | Asynchronous flag: bias monitor voltage over limit |
| pd_hi_async | input | 1 | Asynchronous flag: photodiode current over 150% of target |
| bias_code_wr | input | 1 | Write strobe for the bias DAC code |
| bias_code | input | CODE_W | New bias DAC code |
| bias_on | output | 1 | Bias current enable |
| mod_on | output | 1 | Modulation current enable |
| fault_flag | output | 1 | Latched fault indication |

## Verification
A latch stuck in the wrong state shows on fault_flag at the next edge. It also holds the enables low, so a missed clear is visible right away as well. Disable-run and resume counters that are off by one move the edge where the flag clears, or where the enables come back, by one cycle. A reference model compares the outputs on every clock, so such a shift is seen at the cycle it happens. A stale or lost step-drop memory shows only when a disable is released. The bench therefore writes drops before, between and during disables and watches the first edge after each release.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

   typedef struct packed {
      logic mon_hi;
      logic pd_hi;
      logic step_drop;
   } lsf_src_t;

   function automatic int cnt_width(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/lsf_flag_sync.sv
module lsf_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d_async;
         end
         assign q_sync = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d_async};
         end
         assign q_sync = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lsf_step_watch.sv
module lsf_step_watch #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CODE_W-1:0] code,
   input  logic              arm,
   input  logic              clr,
   output logic              pending
);
   localparam int EXT_W = CODE_W + 1;

   logic [CODE_W-1:0] last_code;
   logic [EXT_W-1:0]  twice_new;
   logic [EXT_W-1:0]  old_ext;
   logic              drop_hit;

   assign twice_new = {code, 1'b0};
   assign old_ext   = {1'b0, last_code};
   assign drop_hit  = wr && arm && (twice_new < old_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  last_code <= '0;
      else if (wr) last_code <= code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending <= 1'b0;
      else if (clr)      pending <= 1'b0;
      else if (drop_hit) pending <= 1'b1;
   end
endmodule

// File: rtl/lsf_run_timer.sv
module lsf_run_timer #(
   parameter int LIMIT = 8,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/lsf_fault_guard.sv
module lsf_fault_guard #(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 13,
   parameter int RESUME_CYC  = 125000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_enable,
   input  logic              tx_disable,
   input  logic              fault_arm,
   input  logic              mon_hi_async,
   input  logic              pd_hi_async,
   input  logic              bias_code_wr,
   input  logic [CODE_W-1:0] bias_code,
   output logic              bias_on,
   output logic              mod_on,
   output logic              fault_flag
);
   import lsf_pkg::*;

   localparam int DIS_CW = cnt_width(RST_CYC);
   localparam int RES_CW = cnt_width(RESUME_CYC);
   localparam logic [DIS_CW-1:0] DIS_LAST = DIS_CW'(RST_CYC - 1);
   localparam logic [RES_CW-1:0] RES_DONE = RES_CW'(RESUME_CYC);

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("lsf_fault_guard: CODE_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("lsf_fault_guard: SYNC_STAGES must be at least 1");
      end
      if (RST_CYC < 1) begin : g_bad_rst
         $error("lsf_fault_guard: RST_CYC must be at least 1");
      end
      if (RESUME_CYC < 1) begin : g_bad_res
         $error("lsf_fault_guard: RESUME_CYC must be at least 1");
      end
   endgenerate

   logic              dis_req;
   logic              mon_sync;
   logic              pd_sync;
   logic              step_pend;
   logic              clr_latch;
   logic              fault_live;
   logic              latch_q;
   logic              resume_run;
   logic [DIS_CW-1:0] dis_cnt;
   logic [RES_CW-1:0] res_cnt;
   lsf_src_t          src;

   assign dis_req = tx_disable | ~drv_enable;

   lsf_flag_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
      .clk(clk), .rst_n(rst_n), .d_async(mon_hi_async), .q_sync(mon_sync));

   lsf_flag_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pd_hi_async), .q_sync(pd_sync));

   lsf_step_watch #(.CODE_W(CODE_W)) u_step (
      .clk(clk), .rst_n(rst_n), .wr(bias_code_wr), .code(bias_code),
      .arm(fault_arm), .clr(clr_latch), .pending(step_pend));

   lsf_run_timer #(.LIMIT(RST_CYC), .CW(DIS_CW)) u_dis_timer (
      .clk(clk), .rst_n(rst_n), .run(dis_req), .cnt(dis_cnt));

   assign clr_latch = dis_req && (dis_cnt == DIS_LAST);

   assign src.mon_hi    = mon_sync;
   assign src.pd_hi     = pd_sync;
   assign src.step_drop = step_pend;
   assign fault_live    = fault_arm && (|src);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      latch_q <= 1'b0;
      else if (clr_latch)              latch_q <= 1'b0;
      else if (!dis_req && fault_live) latch_q <= 1'b1;
   end

   assign resume_run = !(dis_req || latch_q || fault_live);

   lsf_run_timer #(.LIMIT(RESUME_CYC), .CW(RES_CW)) u_res_timer (
      .clk(clk), .rst_n(rst_n), .run(resume_run), .cnt(res_cnt));

   assign bias_on    = !dis_req && !latch_q && (res_cnt == RES_DONE);
   assign mod_on     = !dis_req && !latch_q && (res_cnt == RES_DONE);
   assign fault_flag = latch_q;
endmodule

// File: rtl/lsf_guard_chk.sv
module lsf_guard_chk #(
   parameter int RST_CYC = 13
) (
   input logic clk,
   input logic rst_n,
   input logic drv_enable,
   input logic tx_disable,
   input logic fault_arm,
   input logic mon_sync,
   input logic pd_sync,
   input logic bias_on,
   input logic mod_on,
   input logic fault_flag
);
   localparam int CW = $clog2(RST_CYC + 1);
   localparam logic [CW-1:0] TOP  = CW'(RST_CYC);
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   logic          dis;
   logic [CW-1:0] run_len;

   assign dis = tx_disable | ~drv_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_len <= '0;
      else if (!dis)           run_len <= '0;
      else if (run_len != TOP) run_len <= run_len + 1'b1;
   end

   AST_ARMED_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_arm && (mon_sync || pd_sync) && !dis |=> fault_flag); // R2
   AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      dis |-> !bias_on && !mod_on); // R3
   AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_arm && !fault_flag |=> !fault_flag); // R5
   AST_SHORT_PULSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag && (!dis || run_len < LAST) |=> fault_flag); // R6
   AST_LONG_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dis && run_len == LAST |=> !fault_flag); // R7
   AST_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      dis && run_len == TOP |-> !fault_flag); // R7
   AST_ENABLES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      bias_on == mod_on); // R10
   AST_FLAG_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> !bias_on); // R10
endmodule

bind lsf_fault_guard lsf_guard_chk #(.RST_CYC(RST_CYC)) u_guard_chk (
   .clk(clk), .rst_n(rst_n), .drv_enable(drv_enable), .tx_disable(tx_disable),
   .fault_arm(fault_arm), .mon_sync(mon_sync), .pd_sync(pd_sync),
   .bias_on(bias_on), .mod_on(mod_on), .fault_flag(fault_flag));

// File: tb/lsf_fault_guard_tb.sv
module lsf_fault_guard_tb_top;
   localparam int W   = 8;
   localparam int SYN = 2;
   localparam int RST = 8;
   localparam int RES = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ena = 1'b1;
   logic dis = 1'b0;
   logic arm = 1'b1;
   logic mon = 1'b0;
   logic pd = 1'b0;
   logic wr = 1'b0;
   logic [W-1:0] code = '0;
   logic bias_on, mod_on, fault_flag;

   int vectors = 0;
   int errors = 0;
   string req = "R1";
   bit done = 1'b0;

   // reference model state
   int m_pipe[$];
   int p_pipe[$];
   int m_latch = 0, m_drop = 0, m_prev = 0, m_run = 0, m_res = 0;

   always #4 clk = ~clk;

   lsf_fault_guard #(.CODE_W(W), .SYNC_STAGES(SYN), .RST_CYC(RST), .RESUME_CYC(RES)) dut_i (
      .clk(clk), .rst_n(rst_n), .drv_enable(ena), .tx_disable(dis), .fault_arm(arm),
      .mon_hi_async(mon), .pd_hi_async(pd), .bias_code_wr(wr), .bias_code(code),
      .bias_on(bias_on), .mod_on(mod_on), .fault_flag(fault_flag));

   initial begin
      for (int i = 0; i < SYN; i++) begin
         m_pipe.push_back(0);
         p_pipe.push_back(0);
      end
   end

   always @(posedge clk) begin
      int d, live, clr, ms, ps, nd;
      int exp_on, exp_flag;
      if (!rst_n) begin
         m_latch = 0; m_drop = 0; m_prev = 0; m_run = 0; m_res = 0;
         for (int i = 0; i < SYN; i++) begin
            m_pipe[i] = 0;
            p_pipe[i] = 0;
         end
      end else begin
         d    = (dis || !ena) ? 1 : 0;
         ms   = m_pipe[SYN-1];
         ps   = p_pipe[SYN-1];
         live = (arm && (ms || ps || m_drop)) ? 1 : 0;
         clr  = (d && m_run == RST - 1) ? 1 : 0;
         nd   = (wr && arm && (2 * int'(code) < m_prev)) ? 1 : 0;
         if (wr) m_prev = int'(code);
         if (clr) m_drop = 0;
         else if (nd) m_drop = 1;
         if (d || m_latch || live) m_res = 0;
         else if (m_res < RES) m_res++;
         if (clr) m_latch = 0;
         else if (!d && live) m_latch = 1;
         if (d) begin
            if (m_run < RST) m_run++;
         end else m_run = 0;
         void'(m_pipe.pop_back());
         m_pipe.push_front(int'(mon));
         void'(p_pipe.pop_back());
         p_pipe.push_front(int'(pd));
      end
      #3;
      d = (dis || !ena) ? 1 : 0;
      exp_flag = rst_n ? m_latch : 0;
      exp_on   = (rst_n && !d && !m_latch && m_res == RES) ? 1 : 0;
      vectors++;
      if (int'(fault_flag) != exp_flag || int'(bias_on) != exp_on || int'(mod_on) != exp_on) begin
         errors++;
         $display("FAIL %s t=%0t flag=%0d bias=%0d mod=%0d expected flag=%0d bias=%0d mod=%0d",
                  req, $time, fault_flag, bias_on, mod_on, exp_flag, exp_on, exp_on);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_code(input int v);
      @(negedge clk);
      wr = 1'b1;
      code = W'(v);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pulse_dis(input int n);
      @(negedge clk);
      dis = 1'b1;
      cyc(n);
      dis = 1'b0;
   endtask

   initial begin
      // R1: reset state, then resume delay
      req = "R1";
      cyc(3);
      rst_n = 1'b1;
      cyc(RES + 5);
      // R3: pin disable and enable-bit disable
      req = "R3";
      pulse_dis(3);
      cyc(RES + 4);
      @(negedge clk); ena = 1'b0;
      cyc(4); ena = 1'b1;
      cyc(RES + 4);
      // R2: photodiode flag latches; R6 short pulse keeps it
      req = "R2";
      @(negedge clk); pd = 1'b1;
      cyc(2); pd = 1'b0;
      cyc(10);
      req = "R6";
      pulse_dis(RST - 4);
      cyc(5);
      pulse_dis(RST - 1);
      cyc(5);
      // R7: full-length disable clears; R8 resume when fault gone
      req = "R7";
      pulse_dis(RST + 2);
      req = "R8";
      cyc(RES + 4);
      // R2 monitor flag held; R7 flag low during disable; R8 reassert
      req = "R2";
      @(negedge clk); mon = 1'b1;
      cyc(6);
      req = "R7";
      pulse_dis(RST + 3);
      req = "R8";
      cyc(8);
      mon = 1'b0;
      cyc(4);
      pulse_dis(RST);
      cyc(RES + 4);
      // R5: unarmed sources ignored
      req = "R5";
      @(negedge clk); arm = 1'b0; pd = 1'b1; mon = 1'b1;
      cyc(6);
      pd = 1'b0; mon = 1'b0;
      put_code(255);
      put_code(1);
      cyc(3);
      arm = 1'b1;
      cyc(6);
      // R4: step drop compare, exact half is not a fault
      req = "R4";
      put_code(100);
      put_code(50);
      cyc(4);
      put_code(24);
      cyc(5);
      pulse_dis(RST + 1);
      cyc(RES + 4);
      // R9: drop written during a disable that has already cleared
      req = "R9";
      put_code(200);
      @(negedge clk); dis = 1'b1;
      cyc(RST + 1);
      wr = 1'b1; code = W'(10);
      @(negedge clk); wr = 1'b0;
      cyc(2);
      dis = 1'b0;
      cyc(6);
      pulse_dis(RST);
      cyc(RES + 4);
      // R10: enables stay paired through a final fault and recovery
      req = "R10";
      put_code(3);
      cyc(4);
      pulse_dis(RST);
      cyc(RES + 4);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog %s expired: actual hung expected finished", req);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule